// File: doc/BRIEF.md
# Staged Sorting 3x3 Window Median

This unit takes one 3x3 window of pixels per clock and returns the median of the nine values. It also returns the smallest and the largest value in the window, which is what an adaptive noise filter needs to decide between the centre pixel and the median. It never sorts all nine values. It works in three passes of three-element sorts:

1. Each row is put in ascending order.
2. Each column of that row-ordered matrix is put in ascending order.
3. The three elements on the anti-diagonal are ordered (top-right, centre, bottom-left), and the middle one of them is the median.

After the column pass, the top-left element is the window minimum and the bottom-right element is the window maximum.

Each pass is one register stage. Results therefore leave the unit three clocks after the window enters, and a new window can be accepted on every clock. A valid flag travels with the data. The windows are supplied from outside, because forming them from a pixel stream is not part of this block.

Top module: `med3x3_top`

## Requirements
- R1: While reset is asserted and on the first clock after reset, `outValid` is 0 and `outMed`, `outMin` and `outMax` are all 0.
- R2: `outMed` equals the fifth smallest of the nine input pixels, counting duplicates. Pixel k (k = row*3+col) sits at bits [k*PIX_W +: PIX_W] of `inPix`.
- R3: `outMin` equals the smallest of the nine input pixels.
- R4: `outMax` equals the largest of the nine input pixels.
- R5: `outValid` is 1 exactly three clock edges after `inValid` was sampled as 1, and 0 otherwise. The outputs carry the result of the window that was sampled at that edge.
- R6: Windows presented on consecutive clocks produce results on consecutive clocks, with no gaps and no stalls.
- R7: Windows that hold repeated values give the correct median, minimum and maximum. This covers all-equal windows and windows made only of 0 and 2^PIX_W-1.
- R8: While `outValid` is 0, `outMed`, `outMin` and `outMax` keep the values of the last valid result, or 0 if no valid result has appeared since reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | The window on `inPix` is to be processed |
| inPix | input | 9*PIX_W | Nine pixels, row-major, pixel 0 in the low bits |
| outValid | output | 1 | The result outputs hold a new result |
| outMed | output | PIX_W | Median of the window |
| outMin | output | PIX_W | Minimum of the window |
| outMax | output | PIX_W | Maximum of the window |

## Verification
A stage that drops its ordering, or picks the wrong diagonal, does not always break the median. It shows up only on windows whose values are spread across rows and columns, so random windows are applied against a full nine-value sort. Every such window is checked three clocks after entry. A fault in the valid chain or in the stage load strobes shows up at once as a shifted or missing `outValid`, or as outputs that change during gaps, so the bench inserts idle cycles between bursts. Saturated and all-equal windows exercise the tie handling of the compare-exchange cells.

// File: rtl/med3x3_pkg.sv
package med3x3_pkg;
  localparam int unsigned NUM_STAGES = 3;
  localparam int unsigned WIN_DIM    = 3;
  localparam int unsigned WIN_PIX    = WIN_DIM * WIN_DIM;

  // load strobes from control to datapath, one per register stage
  typedef struct packed {
    logic ldRow;
    logic ldCol;
    logic ldOut;
  } stageStrobe_t;
endpackage

// File: rtl/med3x3_sort3.sv
module med3x3_sort3 #(
  parameter int unsigned PIX_W = 8
) (
  input  logic [PIX_W-1:0] a,
  input  logic [PIX_W-1:0] b,
  input  logic [PIX_W-1:0] c,
  output logic [PIX_W-1:0] lo,
  output logic [PIX_W-1:0] mid,
  output logic [PIX_W-1:0] hi
);
  logic [PIX_W-1:0] x0, x1, y1, y2;

  // three compare-exchange steps; ties may go either way
  always_comb begin
    x0 = (a <= b) ? a : b;
    x1 = (a <= b) ? b : a;
    y1 = (x1 <= c) ? x1 : c;
    y2 = (x1 <= c) ? c : x1;
    lo  = (x0 <= y1) ? x0 : y1;
    mid = (x0 <= y1) ? y1 : x0;
    hi  = y2;
  end
endmodule

// File: rtl/med3x3_ctrl.sv
module med3x3_ctrl
  import med3x3_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output stageStrobe_t strobe,
  output logic         outValid
);
  logic [NUM_STAGES-1:0] vPipe;
  logic                  afterRst;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vPipe    <= '0;
      afterRst <= 1'b0;
    end else begin
      vPipe    <= {vPipe[NUM_STAGES-2:0], inValid};
      afterRst <= 1'b1;
    end
  end

  always_comb begin
    strobe.ldRow = inValid;
    strobe.ldCol = vPipe[0];
    strobe.ldOut = vPipe[1];
  end

  assign outValid = vPipe[NUM_STAGES-1];

  a_r5_valid_step: assert property (@(posedge clk) disable iff (!rstN)
    afterRst |-> (vPipe[0] == $past(inValid)));
  a_r6_chain: assert property (@(posedge clk) disable iff (!rstN)
    afterRst && $past(vPipe[1]) |-> outValid);
endmodule

// File: rtl/med3x3_dp.sv
module med3x3_dp
  import med3x3_pkg::*;
#(
  parameter int unsigned PIX_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  stageStrobe_t             strobe,
  input  logic                     outValid,
  input  logic [WIN_PIX*PIX_W-1:0] inPix,
  output logic [PIX_W-1:0]         medOut,
  output logic [PIX_W-1:0]         minOut,
  output logic [PIX_W-1:0]         maxOut
);
  typedef logic [PIX_W-1:0] pix_t;

  pix_t winIn  [WIN_DIM][WIN_DIM];
  pix_t rowNxt [WIN_DIM][WIN_DIM];
  pix_t rowReg [WIN_DIM][WIN_DIM];
  pix_t colNxt [WIN_DIM][WIN_DIM];
  pix_t colReg [WIN_DIM][WIN_DIM];
  pix_t diagLo, diagMid, diagHi;

  for (genvar r = 0; r < WIN_DIM; r++) begin : g_unpack_r
    for (genvar c = 0; c < WIN_DIM; c++) begin : g_unpack_c
      assign winIn[r][c] = inPix[(r*WIN_DIM+c)*PIX_W +: PIX_W];
    end
  end

  // pass 1: order each row
  for (genvar r = 0; r < WIN_DIM; r++) begin : g_row
    med3x3_sort3 #(.PIX_W(PIX_W)) u_rowSort (
      .a(winIn[r][0]), .b(winIn[r][1]), .c(winIn[r][2]),
      .lo(rowNxt[r][0]), .mid(rowNxt[r][1]), .hi(rowNxt[r][2]));
  end

  // pass 2: order each column of the row-ordered matrix
  for (genvar c = 0; c < WIN_DIM; c++) begin : g_col
    med3x3_sort3 #(.PIX_W(PIX_W)) u_colSort (
      .a(rowReg[0][c]), .b(rowReg[1][c]), .c(rowReg[2][c]),
      .lo(colNxt[0][c]), .mid(colNxt[1][c]), .hi(colNxt[2][c]));
  end

  // pass 3: anti-diagonal, middle element is the median
  med3x3_sort3 #(.PIX_W(PIX_W)) u_diagSort (
    .a(colReg[0][2]), .b(colReg[1][1]), .c(colReg[2][0]),
    .lo(diagLo), .mid(diagMid), .hi(diagHi));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < WIN_DIM; r++)
        for (int c = 0; c < WIN_DIM; c++) begin
          rowReg[r][c] <= '0;
          colReg[r][c] <= '0;
        end
      medOut <= '0;
      minOut <= '0;
      maxOut <= '0;
    end else begin
      if (strobe.ldRow) rowReg <= rowNxt;
      if (strobe.ldCol) colReg <= colNxt;
      if (strobe.ldOut) begin
        medOut <= diagMid;
        minOut <= colReg[0][0];
        maxOut <= colReg[WIN_DIM-1][WIN_DIM-1];
      end
    end
  end

  a_r2_rows_ordered: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ldCol |-> (rowReg[0][0] <= rowReg[0][1]) && (rowReg[0][1] <= rowReg[0][2]) &&
                     (rowReg[2][0] <= rowReg[2][1]) && (rowReg[2][1] <= rowReg[2][2]));
  a_r2_cols_keep_rows: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ldOut |-> (colReg[1][0] <= colReg[1][1]) && (colReg[1][1] <= colReg[1][2]) &&
                     (colReg[0][1] <= colReg[1][1]) && (colReg[1][1] <= colReg[2][1]));
  a_r3_min_le_med: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> minOut <= medOut);
  a_r4_med_le_max: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> medOut <= maxOut);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(medOut) && $stable(minOut) && $stable(maxOut));
endmodule

// File: rtl/med3x3_top.sv
module med3x3_top
  import med3x3_pkg::*;
#(
  parameter int unsigned PIX_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [9*PIX_W-1:0]   inPix,
  output logic                 outValid,
  output logic [PIX_W-1:0]     outMed,
  output logic [PIX_W-1:0]     outMin,
  output logic [PIX_W-1:0]     outMax
);
  stageStrobe_t strobe;

  med3x3_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .strobe(strobe), .outValid(outValid));

  med3x3_dp #(.PIX_W(PIX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .outValid(outValid),
    .inPix(inPix), .medOut(outMed), .minOut(outMin), .maxOut(outMax));
endmodule

// File: tb/med3x3_top_bench.sv
module med3x3_top_bench;
  localparam int W = 8;
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [9*W-1:0] inPix = '0;
  logic outValid;
  logic [W-1:0] outMed, outMin, outMax;

  int nChk = 0;
  int nFail = 0;
  bit done = 0;

  logic        eV [3];
  logic [W-1:0] eMed [3], eMin [3], eMax [3];
  logic [W-1:0] lastMed = '0, lastMin = '0, lastMax = '0;

  always #10 clk = ~clk;

  med3x3_top #(.PIX_W(W)) u_med3x3_top (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inPix(inPix),
    .outValid(outValid), .outMed(outMed), .outMin(outMin), .outMax(outMax));

  function automatic logic [W-1:0] kth(input logic [9*W-1:0] p, input int k);
    logic [W-1:0] v [9];
    logic [W-1:0] t;
    for (int i = 0; i < 9; i++) v[i] = p[i*W +: W];
    for (int i = 0; i < 9; i++)
      for (int j = 0; j < 8 - i; j++)
        if (v[j] > v[j+1]) begin t = v[j]; v[j] = v[j+1]; v[j+1] = t; end
    return v[k];
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock: check the result of the window driven three steps earlier, then drive
  task automatic step(input logic v, input logic [9*W-1:0] p);
    @(negedge clk);
    check("R5 valid", {7'd0, outValid}, {7'd0, eV[2]});
    if (eV[2]) begin
      check("R2 median", outMed, eMed[2]);
      check("R3 min", outMin, eMin[2]);
      check("R4 max", outMax, eMax[2]);
      lastMed = eMed[2]; lastMin = eMin[2]; lastMax = eMax[2];
    end else begin
      check("R8 hold med", outMed, lastMed);
      check("R8 hold min", outMin, lastMin);
      check("R8 hold max", outMax, lastMax);
    end
    for (int i = 2; i > 0; i--) begin
      eV[i] = eV[i-1]; eMed[i] = eMed[i-1]; eMin[i] = eMin[i-1]; eMax[i] = eMax[i-1];
    end
    eV[0] = v;
    eMed[0] = kth(p, 4); eMin[0] = kth(p, 0); eMax[0] = kth(p, 8);
    inValid = v;
    inPix = p;
  endtask

  function automatic logic [9*W-1:0] randWin();
    logic [9*W-1:0] p;
    for (int i = 0; i < 9; i++) p[i*W +: W] = W'($urandom);
    return p;
  endfunction

  function automatic logic [9*W-1:0] satWin();
    logic [9*W-1:0] p;
    for (int i = 0; i < 9; i++) p[i*W +: W] = $urandom_range(1) ? TOP : '0;
    return p;
  endfunction

  initial begin
    #3000000;
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic [9*W-1:0] p;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 3; i++) begin eV[i] = 0; eMed[i] = '0; eMin[i] = '0; eMax[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state during reset
    check("R1 valid in reset", {7'd0, outValid}, 8'd0);
    check("R1 med in reset", outMed, '0);
    check("R1 min in reset", outMin, '0);
    check("R1 max in reset", outMax, '0);
    rstN = 1'b1;
    step(0, '0);
    // R7: directed tie cases
    step(1, '0);
    step(1, {9{TOP}});
    step(1, {9{8'd77}});
    p = '0;
    for (int i = 0; i < 9; i++) p[i*W +: W] = W'(i * 20);
    step(1, p);
    for (int i = 0; i < 9; i++) p[i*W +: W] = W'(200 - i * 20);
    step(1, p);
    p = {TOP, TOP, TOP, TOP, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0};
    step(1, p);
    p = {8'd0, 8'd0, 8'd0, 8'd0, TOP, TOP, TOP, TOP, TOP};
    step(1, p);
    for (int i = 0; i < 4; i++) step(0, randWin());
    // R6: back-to-back random bursts with idle gaps between them
    for (int b = 0; b < 200; b++) begin
      for (int k = 0; k < 20; k++) step(1, randWin());
      for (int k = 0; k < 5; k++) step(1, satWin());
      for (int k = 0; k < int'($urandom_range(3)); k++) step(0, randWin());
      step(1, randWin());
      step(0, randWin());
    end
    for (int i = 0; i < 5; i++) step(0, '0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule